// File: doc/BRIEF.md
# Age-Addressed Operand Belt

This block holds the most recent results of a datapath as a fixed-length queue whose entries are named by age, not by register number. Position 0 is always the newest operand. Each cycle, up to `DROP_SLOTS` functional-unit results enter at the front. Everything already held moves back by the number of arrivals, and whatever moves past the last position is lost. Because of this, the position that names a given operand grows with every drop. A consumer must read an operand before it leaves the back.

Two combinational read ports return the data and valid flag held at a requested position. A rescue command rebuilds the whole belt from a list of positions and a count, and takes effect at the clock edge that ends the cycle. Rescue positions index a window of twice the belt length. The window holds the cycle's arrivals first, in slot order, followed by the belt contents from the start of the cycle. A rescue can therefore recover operands that the same cycle's drops would otherwise push off the back.

Results are accepted every cycle. There is no ready signal and no back-pressure: a drop that is flagged valid is always taken.

Top module: `operand_belt`

## Requirements
- R1: After reset, every position reads back with valid low.
- R2: With no rescue, a single result on slot 0 appears at position 0 on the next cycle, and each older operand moves from position i to position i+1.
- R3: With no rescue, the valid drop slots are compacted in ascending slot order. The lowest valid slot goes to position 0, invalid slots leave no gap, and older operands move back by the number of valid drops. Slot s data is `drop_data[s*W +: W]` and its flag is `drop_vld[s]`.
- R4: An operand pushed beyond position `BELT_LEN-1` is discarded. A cycle with no drops and no rescue leaves every position unchanged.
- R5: Read port k, with its position at `rd_pos[k*AW +: AW]`, returns the stored data and valid flag of that position in the same cycle, on `rd_data[k*W +: W]` and `rd_vld[k]`. The two ports are independent.
- R6: A rescue with count c places the window entries named by list fields 0 to c-1 at positions 0 to c-1, in list order. Every position from c upward becomes invalid. Field i is `rescue_pos[i*PW +: PW]`.
- R7: In a rescue cycle, window index j below the number of valid drops d holds the j-th compacted drop. Index j from d to d+BELT_LEN-1 holds the pre-cycle position j-d. Any higher index up to 2*BELT_LEN-1 is invalid.
- R8: A rescue with count 0 leaves the whole belt invalid.
- R9: List fields at or beyond the rescue count have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drop_vld | input | DROP_SLOTS | Per-slot result present |
| drop_data | input | DROP_SLOTS*DATA_W | Per-slot result data, slot 0 in the low bits |
| rescue_en | input | 1 | Rebuild the belt from the rescue list at this edge |
| rescue_cnt | input | CW | Number of list fields used (0 to BELT_LEN) |
| rescue_pos | input | BELT_LEN*PW | Window indices, field 0 in the low bits |
| rd_pos | input | RD_PORTS*AW | Read positions, port 0 in the low bits |
| rd_data | output | RD_PORTS*DATA_W | Read data, port 0 in the low bits |
| rd_vld | output | RD_PORTS | Read position holds a live operand |

## Verification
The assertions assume that `rescue_cnt` never exceeds `BELT_LEN` and that `DROP_SLOTS` is no larger than the belt length. The stimulus keeps the count between 0 and 16 on a 16-entry belt with four slots. Rescue indices are generated arithmetically over the full 32-entry window, so some of them land beyond the live window on purpose. Drop patterns sweep all sixteen slot masks, which covers gaps, single drops and full-width drops, while the belt is both partly and fully occupied.

// File: rtl/belt_pkg.sv
package belt_pkg;
  localparam int DEF_BELT_LEN   = 16;
  localparam int DEF_DROP_SLOTS = 4;
  localparam int DEF_DATA_W     = 32;
  localparam int DEF_RD_PORTS   = 2;
endpackage

// File: rtl/belt_window.sv
module belt_window #(
  parameter int N = 16,
  parameter int D = 4,
  parameter int W = 32,
  localparam int WIN = 2 * N
) (
  input  logic [N-1:0]          cur_vld,
  input  logic [N-1:0][W-1:0]   cur_data,
  input  logic [D-1:0]          drop_vld,
  input  logic [D-1:0][W-1:0]   drop_data,
  output logic [WIN-1:0]        win_vld,
  output logic [WIN-1:0][W-1:0] win_data
);
  // arrivals first (compacted by slot order), then the pre-cycle belt
  always_comb begin
    int nd;
    nd = 0;
    win_vld  = '0;
    win_data = '0;
    for (int s = 0; s < D; s++) begin
      if (drop_vld[s]) begin
        win_vld[nd]  = 1'b1;
        win_data[nd] = drop_data[s];
        nd = nd + 1;
      end
    end
    for (int i = 0; i < N; i++) begin
      win_vld[i + nd]  = cur_vld[i];
      win_data[i + nd] = cur_data[i];
    end
  end
endmodule

// File: rtl/belt_rescue.sv
module belt_rescue #(
  parameter int N  = 16,
  parameter int W  = 32,
  parameter int PW = 5,
  parameter int CW = 5
) (
  input  logic                    rescue_en,
  input  logic [CW-1:0]           rescue_cnt,
  input  logic [N-1:0][PW-1:0]    rescue_pos,
  input  logic [2*N-1:0]          win_vld,
  input  logic [2*N-1:0][W-1:0]   win_data,
  output logic [N-1:0]            nxt_vld,
  output logic [N-1:0][W-1:0]     nxt_data
);
  for (genvar g = 0; g < N; g++) begin : g_pos
    always_comb begin
      if (!rescue_en) begin
        nxt_vld[g]  = win_vld[g];
        nxt_data[g] = win_data[g];
      end else if (CW'(g) < rescue_cnt) begin
        nxt_vld[g]  = win_vld[rescue_pos[g]];
        nxt_data[g] = win_data[rescue_pos[g]];
      end else begin
        nxt_vld[g]  = 1'b0;
        nxt_data[g] = '0;
      end
    end
  end
endmodule

// File: rtl/belt_read_port.sv
module belt_read_port #(
  parameter int N  = 16,
  parameter int W  = 32,
  parameter int AW = 4
) (
  input  logic [AW-1:0]        pos,
  input  logic [N-1:0]         ent_vld,
  input  logic [N-1:0][W-1:0]  ent_data,
  output logic                 vld,
  output logic [W-1:0]         data
);
  assign vld  = ent_vld[pos];
  assign data = ent_data[pos];
endmodule

// File: rtl/operand_belt.sv
module operand_belt
  import belt_pkg::*;
#(
  parameter int BELT_LEN   = DEF_BELT_LEN,
  parameter int DROP_SLOTS = DEF_DROP_SLOTS,
  parameter int DATA_W     = DEF_DATA_W,
  parameter int RD_PORTS   = DEF_RD_PORTS,
  localparam int AW = $clog2(BELT_LEN),
  localparam int PW = $clog2(2 * BELT_LEN),
  localparam int CW = $clog2(BELT_LEN + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [DROP_SLOTS-1:0]         drop_vld,
  input  logic [DROP_SLOTS*DATA_W-1:0]  drop_data,
  input  logic                          rescue_en,
  input  logic [CW-1:0]                 rescue_cnt,
  input  logic [BELT_LEN*PW-1:0]        rescue_pos,
  input  logic [RD_PORTS*AW-1:0]        rd_pos,
  output logic [RD_PORTS*DATA_W-1:0]    rd_data,
  output logic [RD_PORTS-1:0]           rd_vld
);
  logic [BELT_LEN-1:0]                ent_vld_q, nxt_vld;
  logic [BELT_LEN-1:0][DATA_W-1:0]    ent_data_q, nxt_data;
  logic [2*BELT_LEN-1:0]              win_vld;
  logic [2*BELT_LEN-1:0][DATA_W-1:0]  win_data;
  logic [DROP_SLOTS-1:0][DATA_W-1:0]  drops;
  logic [BELT_LEN-1:0][PW-1:0]        pos_list;

  assign drops    = drop_data;
  assign pos_list = rescue_pos;

  belt_window #(.N(BELT_LEN), .D(DROP_SLOTS), .W(DATA_W)) u_window (
    .cur_vld  (ent_vld_q),
    .cur_data (ent_data_q),
    .drop_vld (drop_vld),
    .drop_data(drops),
    .win_vld  (win_vld),
    .win_data (win_data)
  );

  belt_rescue #(.N(BELT_LEN), .W(DATA_W), .PW(PW), .CW(CW)) u_rescue (
    .rescue_en (rescue_en),
    .rescue_cnt(rescue_cnt),
    .rescue_pos(pos_list),
    .win_vld   (win_vld),
    .win_data  (win_data),
    .nxt_vld   (nxt_vld),
    .nxt_data  (nxt_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld_q  <= '0;
      ent_data_q <= '0;
    end else begin
      ent_vld_q  <= nxt_vld;
      ent_data_q <= nxt_data;
    end
  end

  for (genvar k = 0; k < RD_PORTS; k++) begin : g_rd
    belt_read_port #(.N(BELT_LEN), .W(DATA_W), .AW(AW)) u_port (
      .pos     (rd_pos[k*AW +: AW]),
      .ent_vld (ent_vld_q),
      .ent_data(ent_data_q),
      .vld     (rd_vld[k]),
      .data    (rd_data[k*DATA_W +: DATA_W])
    );
  end
endmodule

// File: rtl/belt_chk.sv
module belt_chk #(
  parameter int N   = 16,
  parameter int D   = 4,
  parameter int W   = 32,
  parameter int NRD = 2,
  parameter int AW  = 4,
  parameter int CW  = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [D-1:0]          drop_vld,
  input logic [D*W-1:0]        drop_data,
  input logic                  rescue_en,
  input logic [CW-1:0]         rescue_cnt,
  input logic [N-1:0]          ent_vld,
  input logic [N-1:0][W-1:0]   ent_data,
  input logic [NRD*AW-1:0]     rd_pos,
  input logic [NRD-1:0]        rd_vld
);
  // R1
  reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ent_vld == '0);

  // R2
  front_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rescue_en && drop_vld == D'(1)) |=>
      (ent_vld[0] && ent_data[0] == $past(drop_data[W-1:0])));

  // R3
  front_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rescue_en && drop_vld != '0) |=> ent_vld[0]);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rescue_en && drop_vld == '0) |=> ($stable(ent_vld) && $stable(ent_data)));

  // R6
  rescue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rescue_en |=> $countones(ent_vld) <= int'($past(rescue_cnt)));

  // R8
  rescue_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rescue_en && rescue_cnt == '0) |=> ent_vld == '0);

  for (genvar k = 0; k < NRD; k++) begin : g_rdchk
    // R5
    read_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_vld[k] == ent_vld[rd_pos[k*AW +: AW]]);
  end
endmodule

bind operand_belt belt_chk #(
  .N(BELT_LEN), .D(DROP_SLOTS), .W(DATA_W), .NRD(RD_PORTS),
  .AW($clog2(BELT_LEN)), .CW($clog2(BELT_LEN + 1))
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .drop_vld  (drop_vld),
  .drop_data (drop_data),
  .rescue_en (rescue_en),
  .rescue_cnt(rescue_cnt),
  .ent_vld   (ent_vld_q),
  .ent_data  (ent_data_q),
  .rd_pos    (rd_pos),
  .rd_vld    (rd_vld)
);

// File: tb/operand_belt_tb.sv
`timescale 1ns/10ps
module operand_belt_tb;
  localparam int N = 16, D = 4, W = 16, NRD = 2;
  localparam int AW = 4, PW = 5, CW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [D-1:0]      drop_vld = '0;
  logic [D*W-1:0]    drop_data = '0;
  logic              rescue_en = 1'b0;
  logic [CW-1:0]     rescue_cnt = '0;
  logic [N*PW-1:0]   rescue_pos = '0;
  logic [NRD*AW-1:0] rd_pos = '0;
  logic [NRD*W-1:0]  rd_data;
  logic [NRD-1:0]    rd_vld;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic         mv [N];
  logic [W-1:0] md [N];

  always #2.5 clk = ~clk;

  operand_belt #(.BELT_LEN(N), .DROP_SLOTS(D), .DATA_W(W), .RD_PORTS(NRD)) u_dut (
    .clk(clk), .rst_n(rst_n), .drop_vld(drop_vld), .drop_data(drop_data),
    .rescue_en(rescue_en), .rescue_cnt(rescue_cnt), .rescue_pos(rescue_pos),
    .rd_pos(rd_pos), .rd_data(rd_data), .rd_vld(rd_vld)
  );

  task automatic cmp(input string tag, input int port, input int p);
    logic v; logic [W-1:0] d;
    v = rd_vld[port];
    d = rd_data[port*W +: W];
    n_tests++;
    if (v !== mv[p] || (mv[p] && d !== md[p])) begin
      n_fail++;
      $display("FAIL %s port%0d pos %0d: got v=%b d=%h, expected v=%b d=%h",
               tag, port, p, v, d, mv[p], md[p]);
    end
  endtask

  // R5: both ports swept across every position
  task automatic check_all(input string tag);
    for (int p = 0; p < N; p++) begin
      rd_pos = {AW'(N - 1 - p), AW'(p)};
      #0.1;
      cmp(tag, 0, p);
      cmp({tag, " R5"}, 1, N - 1 - p);
    end
  endtask

  task automatic apply(input logic [D-1:0] dv, input logic [W-1:0] base,
                       input logic ren, input int cnt, input int seed,
                       input int stride, input string tag);
    logic         wv [2*N];
    logic [W-1:0] wd [2*N];
    int k;
    @(negedge clk);
    drop_vld = dv;
    for (int s = 0; s < D; s++) drop_data[s*W +: W] = base + W'(s);
    rescue_en  = ren;
    rescue_cnt = CW'(cnt);
    for (int i = 0; i < N; i++) rescue_pos[i*PW +: PW] = PW'((seed + i * stride) % (2 * N));
    for (int j = 0; j < 2 * N; j++) begin wv[j] = 1'b0; wd[j] = '0; end
    k = 0;
    for (int s = 0; s < D; s++)
      if (dv[s]) begin wv[k] = 1'b1; wd[k] = base + W'(s); k++; end
    for (int i = 0; i < N; i++) begin wv[k + i] = mv[i]; wd[k + i] = md[i]; end
    for (int i = 0; i < N; i++) begin
      if (!ren) begin
        mv[i] = wv[i]; md[i] = wd[i];
      end else if (i < cnt) begin
        mv[i] = wv[(seed + i * stride) % (2 * N)];
        md[i] = wd[(seed + i * stride) % (2 * N)];
      end else begin
        mv[i] = 1'b0; md[i] = '0;
      end
    end
    @(posedge clk);
    #0.5;
    drop_vld = '0; rescue_en = 1'b0;
    check_all(tag);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin mv[i] = 1'b0; md[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #0.5;
    check_all("R1");
    // R2 R3 R4: every slot mask, several passes so old entries fall off
    for (int rep = 0; rep < 3; rep++)
      for (int dv = 0; dv < 16; dv++)
        apply(D'(dv), W'(rep * 256 + dv * 16), 1'b0, 0, 0, 1,
              dv == 1 ? "R2" : (dv == 0 ? "R4 idle" : "R3 R4"));
    // R6: identity keep of the full belt
    apply('0, 16'h0, 1'b1, N, 0, 1, "R6");
    // R6 R7 R8: every count, with and without same-cycle drops
    for (int c = 0; c <= N; c++) begin
      apply(4'hF, W'(16'h4000 + c * 32), 1'b0, 0, 0, 1, "R3");
      apply(4'hF, W'(16'h5000 + c * 32), 1'b0, 0, 0, 1, "R3");
      apply(4'h0, W'(16'h6000), 1'b1, c, c * 3, 5, c == 0 ? "R8" : "R6");
      apply(4'hF, W'(16'h7000 + c * 32), 1'b0, 0, 0, 1, "R3");
      apply(4'b1011, W'(16'h8000 + c * 32), 1'b1, c, c, 7, c == 0 ? "R8" : "R7");
    end
    // R7: reach into the far window, including indices past the live entries
    for (int c = 0; c < 4; c++) begin
      for (int f = 0; f < 4; f++) apply(4'hF, W'(16'h9000 + f * 8), 1'b0, 0, 0, 1, "R3");
      apply(4'b0101, W'(16'hA000), 1'b1, N, 16 + c, 1, "R7 far");
    end
    // R9: same count, different tail fields
    for (int t = 0; t < 4; t++) begin
      for (int f = 0; f < 4; f++) apply(4'hF, W'(16'hB000 + f * 8), 1'b0, 0, 0, 1, "R3");
      apply(4'h0, W'(16'hC000), 1'b1, 3, 2, 1 + 2 * t, "R9");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule